// File: doc/BRIEF.md
# Three-Source Event Builder with Header/Trailer Framing

This block collects the already-reduced data fragments that belong to one trigger from three independent 64-bit input streams. It writes them out as one 64-bit event stream with a header word in front and a trailer word at the end. Each input has its own small FIFO. Every input beat carries a side tag with the event type, the 24-bit event number and the 12-bit bunch-crossing number. The block compares the event numbers at the heads of the three FIFOs before it opens an event. It then drains the sources one after another. It counts the emitted words and runs a 16-bit CRC over the whole frame.

The output uses a valid/ready handshake. A throttle output with hysteresis warns the trigger logic upstream when any input FIFO is close to overflowing. A source that has nothing for an event still sends one beat marked empty, so every event closes on all three inputs.

Top module: `evb_top`

## Requirements
- R1: The header is the first word of each event. Its fields are: bits 63:56 = 0x50, bits 55:52 = event type, bits 51:28 = event number, bits 27:16 = bunch-crossing number (all three taken from source 0's head tag), bits 15:4 = the SRC_ID parameter, bits 3:1 = 0.
- R2: The header is offered only when all three FIFOs hold a beat. Header bit 0 is 1 when the head event numbers of the sources are not all equal, and 0 when they are. In either case all three fragments are forwarded.
- R3: The payload follows the header, with source 0's fragment first, then source 1's, then source 2's. Each fragment runs up to and including its beat flagged last. A beat flagged empty ends the fragment and adds no output word.
- R4: The trailer is the last word of each event, and out_last is high only on it. Its fields are: bits 63:56 = 0xA0, bits 55:32 = total event length in 64-bit words (header and trailer included), bits 15:0 = 0.
- R5: Trailer bits 31:16 hold a CRC with polynomial x^16+x^12+x^5+1. The CRC starts at 0xFFFF and is computed MSB first over each word from the header through the trailer, with the trailer's CRC field taken as zero. There is no final inversion.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle.
- R7: Each input FIFO holds DEPTH beats. When a FIFO is full, its in_ready is low and a beat offered to it is not taken.
- R8: throttle is high in the cycle after any FIFO holds at least 3/4 of DEPTH beats.
- R9: Once high, throttle stays high until every FIFO holds fewer than DEPTH/2 beats, and falls in the cycle after that.
- R10: After reset, out_valid and throttle are low and every in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NSRC | Per-source beat valid |
| in_ready | output | NSRC | Per-source FIFO has room |
| in_data | input | NSRC*64 | Per-source payload word, source i at bits 64i+63:64i |
| in_last | input | NSRC | Beat closes the source's fragment |
| in_empty | input | NSRC | Beat carries no payload and closes the fragment |
| in_tag | input | NSRC*40 | Per-source tag {type[3:0], event number[23:0], bunch crossing[11:0]} |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 64 | Output word |
| out_last | output | 1 | Word is the trailer |
| throttle | output | 1 | Buffer occupancy warning |

## Verification
The bench builds the block with three sources, DEPTH = 8 and a non-trivial source identifier. With these values the 3/4 and 1/2 thresholds (6 and 4 beats) and a completely full FIFO are reached within a handful of beats. The bench steps the output one word at a time, so it can walk the throttle up through its set point, hold it in the hysteresis band and watch it fall. It then runs forty more events whose fragment sizes cycle through 0 to 5 beats per source, in every relative phase, while downstream readiness is gated in a fixed pattern. One of those events carries a mismatched event number on source 1. Every header, payload word, length and CRC is predicted arithmetically in the bench, using a byte-wise CRC formulation.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int WORD_W = 64;
  localparam int TYPE_W = 4;
  localparam int EVN_W  = 24;
  localparam int BX_W   = 12;
  localparam int SID_W  = 12;
  localparam int LEN_W  = 24;
  localparam int CRC_W  = 16;
  localparam int TAG_W  = TYPE_W + EVN_W + BX_W;
  localparam int BEAT_W = 2 + TAG_W + WORD_W;

  localparam logic [7:0]       HDR_MARK = 8'h50;
  localparam logic [7:0]       TRL_MARK = 8'hA0;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic [TYPE_W-1:0] etype;
    logic [EVN_W-1:0]  evn;
    logic [BX_W-1:0]   bx;
  } tag_t;

  typedef struct packed {
    logic              last;
    logic              empty;
    tag_t              tag;
    logic [WORD_W-1:0] data;
  } beat_t;

  typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_TRL} fst_t;

  // Bit-serial CRC over one word, MSB first.
  function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ w[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] make_header(input tag_t t,
                                                    input logic [SID_W-1:0] sid,
                                                    input logic err);
    return {HDR_MARK, t.etype, t.evn, t.bx, sid, 3'b000, err};
  endfunction

  function automatic logic [WORD_W-1:0] make_trailer(input logic [LEN_W-1:0] len,
                                                     input logic [CRC_W-1:0] crc);
    return {TRL_MARK, len, crc, 16'h0000};
  endfunction
endpackage

// File: rtl/evb_fifo.sv
module evb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [W-1:0]  wr_data,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  input  logic          rd_pop,
  output logic [CW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pull;

  assign wr_ready = (cnt != CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];
  assign level    = cnt;
  assign push     = wr_valid && wr_ready;
  assign pull     = rd_pop && rd_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pull) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pull);
    end
  end
endmodule

// File: rtl/evb_throttle.sv
module evb_throttle #(
  parameter int NSRC = 3,
  parameter int CW   = 4,
  parameter int HI   = 6,
  parameter int LO   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC*CW-1:0] levels,
  output logic               throttle
);
  logic any_hi, all_lo;

  always_comb begin
    any_hi = 1'b0;
    all_lo = 1'b1;
    for (int i = 0; i < NSRC; i++) begin
      if (levels[i*CW +: CW] >= CW'(HI)) any_hi = 1'b1;
      if (levels[i*CW +: CW] >= CW'(LO)) all_lo = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         throttle <= 1'b0;
    else if (any_hi) throttle <= 1'b1;
    else if (all_lo) throttle <= 1'b0;
  end
endmodule

// File: rtl/evb_framer.sv
module evb_framer
  import evb_pkg::*;
#(
  parameter int              NSRC   = 3,
  parameter logic [SID_W-1:0] SRC_ID = 12'h001
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        head_valid,
  input  logic [NSRC*BEAT_W-1:0] heads,
  output logic [NSRC-1:0]        pop,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_last,
  output logic                   hdr_fire,
  output logic                   mismatch
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  beat_t             hb [NSRC];
  beat_t             cur;
  fst_t              st;
  logic [IW-1:0]     idx;
  logic [LEN_W-1:0]  len;
  logic [CRC_W-1:0]  crc;
  logic              all_valid, fire, pay_pop, frag_end;
  logic [WORD_W-1:0] hdr_word, trl_word;
  logic [LEN_W-1:0]  trl_len;

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign hb[g] = beat_t'(heads[g*BEAT_W +: BEAT_W]);
  end

  assign cur       = hb[idx];
  assign all_valid = &head_valid;

  always_comb begin
    mismatch = 1'b0;
    for (int i = 1; i < NSRC; i++)
      if (hb[i].tag.evn != hb[0].tag.evn) mismatch = 1'b1;
  end

  assign hdr_word = make_header(hb[0].tag, SRC_ID, mismatch);
  assign trl_len  = len + LEN_W'(1);
  assign trl_word = make_trailer(trl_len, crc_word(crc, make_trailer(trl_len, '0)));

  always_comb begin
    out_valid = 1'b0;
    out_last  = 1'b0;
    out_data  = hdr_word;
    case (st)
      ST_HDR: out_valid = all_valid;
      ST_PAY: begin
        out_valid = head_valid[idx] && !cur.empty;
        out_data  = cur.data;
      end
      default: begin
        out_valid = 1'b1;
        out_last  = 1'b1;
        out_data  = trl_word;
      end
    endcase
  end

  assign fire     = out_valid && out_ready;
  assign hdr_fire = fire && (st == ST_HDR);
  assign pay_pop  = (st == ST_PAY) && head_valid[idx] && (cur.empty || out_ready);
  assign frag_end = pay_pop && (cur.empty || cur.last);

  always_comb begin
    for (int i = 0; i < NSRC; i++) pop[i] = pay_pop && (idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_HDR;
      idx <= '0;
      len <= '0;
      crc <= CRC_SEED;
    end else begin
      case (st)
        ST_HDR: if (fire) begin
          crc <= crc_word(CRC_SEED, hdr_word);
          len <= LEN_W'(1);
          idx <= '0;
          st  <= ST_PAY;
        end
        ST_PAY: begin
          if (fire) begin
            crc <= crc_word(crc, cur.data);
            len <= len + LEN_W'(1);
          end
          if (frag_end) begin
            if (idx == IW'(NSRC - 1)) st <= ST_TRL;
            else                      idx <= idx + IW'(1);
          end
        end
        default: if (fire) st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/evb_top.sv
module evb_top
  import evb_pkg::*;
#(
  parameter int               NSRC   = 3,
  parameter int               DEPTH  = 8,
  parameter logic [SID_W-1:0] SRC_ID = 12'h001
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        in_valid,
  output logic [NSRC-1:0]        in_ready,
  input  logic [NSRC*WORD_W-1:0] in_data,
  input  logic [NSRC-1:0]        in_last,
  input  logic [NSRC-1:0]        in_empty,
  input  logic [NSRC*TAG_W-1:0]  in_tag,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_last,
  output logic                   throttle
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HI = (DEPTH * 3) / 4;
  localparam int LO = DEPTH / 2;

  logic [NSRC*CW-1:0]     fifo_level;
  logic [NSRC-1:0]        head_valid;
  logic [NSRC*BEAT_W-1:0] heads;
  logic [NSRC-1:0]        src_pop;
  logic                   hdr_fire;
  logic                   evn_mismatch;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    beat_t wbeat;
    assign wbeat = '{last:  in_last[g],
                     empty: in_empty[g],
                     tag:   tag_t'(in_tag[g*TAG_W +: TAG_W]),
                     data:  in_data[g*WORD_W +: WORD_W]};

    evb_fifo #(.W(BEAT_W), .DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .wr_valid (in_valid[g]),
      .wr_ready (in_ready[g]),
      .wr_data  (wbeat),
      .rd_valid (head_valid[g]),
      .rd_data  (heads[g*BEAT_W +: BEAT_W]),
      .rd_pop   (src_pop[g]),
      .level    (fifo_level[g*CW +: CW])
    );
  end

  evb_framer #(.NSRC(NSRC), .SRC_ID(SRC_ID)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .head_valid (head_valid),
    .heads      (heads),
    .pop        (src_pop),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .hdr_fire   (hdr_fire),
    .mismatch   (evn_mismatch)
  );

  evb_throttle #(.NSRC(NSRC), .CW(CW), .HI(HI), .LO(LO)) u_thr (
    .clk      (clk),
    .rst      (rst),
    .levels   (fifo_level),
    .throttle (throttle)
  );
endmodule

// File: rtl/evb_top_chk.sv
module evb_top_chk #(
  parameter int NSRC  = 3,
  parameter int DEPTH = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NSRC-1:0]                   in_valid,
  input logic [NSRC-1:0]                   in_ready,
  input logic [NSRC*$clog2(DEPTH+1)-1:0]   levels,
  input logic [NSRC-1:0]                   pop,
  input logic                              hdr_fire,
  input logic                              out_valid,
  input logic                              out_ready,
  input logic                              out_last,
  input logic [63:0]                       out_data,
  input logic                              throttle
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HI = (DEPTH * 3) / 4;
  localparam int LO = DEPTH / 2;

  logic any_hi, all_lo;
  always_comb begin
    any_hi = 1'b0;
    all_lo = 1'b1;
    for (int i = 0; i < NSRC; i++) begin
      if (levels[i*CW +: CW] >= CW'(HI)) any_hi = 1'b1;
      if (levels[i*CW +: CW] >= CW'(LO)) all_lo = 1'b0;
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R3
  one_pop_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(pop));

  // R2
  hdr_not_payload_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_fire |-> (pop == '0) && !out_last);

  // R8
  thr_rise_chk: assert property (@(posedge clk) disable iff (rst) any_hi |=> throttle);

  // R9
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    throttle && !all_lo |=> throttle);

  // R9
  thr_fall_chk: assert property (@(posedge clk) disable iff (rst)
    throttle && all_lo |=> !throttle);

  // R4
  trl_form_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> out_data[63:56] == 8'hA0 && out_data[55:32] >= 24'd2
                              && out_data[15:0] == 16'h0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src_chk
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      levels[g*CW +: CW] == CW'(DEPTH) && !pop[g] |=> levels[g*CW +: CW] == CW'(DEPTH));
    // R7
    full_ready_chk: assert property (@(posedge clk) disable iff (rst)
      levels[g*CW +: CW] == CW'(DEPTH) |-> !in_ready[g]);
  end
endmodule

bind evb_top evb_top_chk #(.NSRC(NSRC), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .levels    (fifo_level),
  .pop       (src_pop),
  .hdr_fire  (hdr_fire),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_data  (out_data),
  .throttle  (throttle)
);

// File: tb/evb_top_test.sv
`timescale 1ns/1ps
module evb_top_test;
  localparam int          NSRC = 3;
  localparam int          DEPTH = 8;
  localparam logic [11:0] SID = 12'h3C5;
  localparam int          NEV = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst;
  logic [NSRC-1:0]      in_valid, in_ready, in_last, in_empty;
  logic [NSRC*64-1:0]   in_data;
  logic [NSRC*40-1:0]   in_tag;
  logic                 out_valid, out_ready, out_last, throttle;
  logic [63:0]          out_data;

  logic        sv [NSRC];
  logic        sl [NSRC];
  logic        se [NSRC];
  logic [63:0] sd [NSRC];
  logic [39:0] st [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_pack
    assign in_valid[g]         = sv[g];
    assign in_last[g]          = sl[g];
    assign in_empty[g]         = se[g];
    assign in_data[g*64 +: 64] = sd[g];
    assign in_tag[g*40 +: 40]  = st[g];
  end

  evb_top #(.NSRC(NSRC), .DEPTH(DEPTH), .SRC_ID(SID)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_empty(in_empty), .in_tag(in_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .throttle(throttle));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---- reference model ----
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [63:0] w);
    for (int b = 7; b >= 0; b--) begin
      c = c ^ {w[b*8 +: 8], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic int flen(input int ev, input int s);
    if (ev == 0) return (s == 0) ? 9 : ((s == 1) ? 0 : 1);
    return (ev * 7 + s * 3) % 6;
  endfunction

  function automatic logic [63:0] dword(input int ev, input int s, input int k);
    return {16'(ev), 8'(s), 8'(k), 32'(ev * 1000 + s * 100 + k) ^ 32'hA5A5_0000};
  endfunction

  function automatic logic [39:0] tag_of(input int ev, input int s);
    logic [23:0] e;
    e = 24'(ev + 256);
    if (ev == 5 && s == 1) e = e ^ 24'h1;
    return {4'(ev), e, 12'(ev * 37)};
  endfunction

  logic [63:0] exp_q [$];
  int          exp_k [$];  // 0 header, 1 payload, 2 trailer

  task automatic build_exp(input int ev);
    logic [39:0] t0;
    logic        err;
    logic [63:0] w, trl0;
    logic [15:0] c;
    int          n;
    t0  = tag_of(ev, 0);
    err = 1'b0;
    for (int s = 1; s < NSRC; s++) if (tag_of(ev, s)[35:12] != t0[35:12]) err = 1'b1;
    w = {8'h50, t0[39:36], t0[35:12], t0[11:0], SID, 3'b000, err};
    c = ref_crc(16'hFFFF, w);
    exp_q.push_back(w); exp_k.push_back(0);
    n = 1;
    for (int s = 0; s < NSRC; s++)
      for (int k = 0; k < flen(ev, s); k++) begin
        w = dword(ev, s, k);
        c = ref_crc(c, w);
        exp_q.push_back(w); exp_k.push_back(1);
        n++;
      end
    n++;
    trl0 = {8'hA0, 24'(n), 32'h0};
    c = ref_crc(c, trl0);
    exp_q.push_back(trl0 | {32'h0, c, 16'h0}); exp_k.push_back(2);
  endtask

  // ---- output monitor and ready control ----
  int          mode = 0;   // 0 hold low, 1 pattern, 2 budget
  int          budget = 0;
  int          cyc = 0;
  bit          prev_stall = 0;
  logic [63:0] prev_data;

  always @(negedge clk) begin
    logic [63:0] e;
    int          k;
    cyc++;
    if (prev_stall)
      chk(out_valid && out_data == prev_data, "R6 stall hold", out_data, prev_data);
    case (mode)
      0:       out_ready = 1'b0;
      1:       out_ready = (cyc % 4 != 1);
      default: out_ready = (budget > 0);
    endcase
    #1;
    prev_stall = !rst && out_valid && !out_ready;
    prev_data  = out_data;
    if (!rst && out_valid && out_ready) begin
      if (mode == 2) budget--;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected word", out_data, 64'h0);
      end else begin
        e = exp_q.pop_front();
        k = exp_k.pop_front();
        chk(out_last == (k == 2), "R4 last flag", 64'(out_last), 64'(k == 2));
        if (k == 0) begin
          chk(out_data[63:1] == e[63:1], "R1 header fields", out_data, e);
          chk(out_data[0] == e[0], "R2 mismatch bit", out_data, e);
        end else if (k == 1) begin
          chk(out_data == e, "R3 payload order", out_data, e);
        end else begin
          chk(out_data[63:32] == e[63:32] && out_data[15:0] == e[15:0], "R4 trailer length",
              out_data, e);
          chk(out_data[31:16] == e[31:16], "R5 trailer CRC", out_data, e);
        end
      end
    end
  end

  // ---- source driving ----
  task automatic push_beat(input int s, input logic [63:0] d, input bit last,
                           input bit empty, input logic [39:0] tag);
    @(negedge clk);
    sv[s] = 1'b1; sd[s] = d; sl[s] = last; se[s] = empty; st[s] = tag;
    #2;
    while (!in_ready[s]) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    sv[s] = 1'b0;
  endtask

  task automatic send_frag(input int ev, input int s);
    int n;
    n = flen(ev, s);
    if (n == 0) push_beat(s, 64'h0, 1'b1, 1'b1, tag_of(ev, s));
    else for (int k = 0; k < n; k++) push_beat(s, dword(ev, s, k), k == n - 1, 1'b0, tag_of(ev, s));
  endtask

  task automatic run_budget(input int n);
    budget = n;
    mode   = 2;
    while (budget != 0) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R3 watchdog expired", 64'(exp_q.size()), 64'h0);
      summary();
    end
  end

  initial begin
    for (int s = 0; s < NSRC; s++) begin
      sv[s] = 0; sl[s] = 0; se[s] = 0; sd[s] = '0; st[s] = '0;
    end
    out_ready = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R10
    chk(!out_valid, "R10 reset out_valid", 64'(out_valid), 64'h0);
    chk(!throttle, "R10 reset throttle", 64'(throttle), 64'h0);
    chk(in_ready == '1, "R10 reset in_ready", 64'(in_ready), 64'h7);

    // Phase 1: fill source 0, walk throttle up and back down.
    build_exp(0);
    for (int k = 0; k < 8; k++) begin
      push_beat(0, dword(0, 0, k), 1'b0, 1'b0, tag_of(0, 0));
      @(negedge clk);
      #2;
      chk(throttle == (k + 1 >= 6), "R8 throttle rise", 64'(throttle), 64'(k + 1 >= 6));
    end
    chk(in_ready[0] == 1'b0, "R7 full ready low", 64'(in_ready[0]), 64'h0);
    chk(!out_valid, "R2 header waits for all sources", 64'(out_valid), 64'h0);
    @(negedge clk);
    sv[0] = 1'b1; sd[0] = dword(0, 0, 8); sl[0] = 1'b1; se[0] = 1'b0; st[0] = tag_of(0, 0);
    repeat (3) @(negedge clk);
    #2;
    chk(in_ready[0] == 1'b0, "R7 full beat refused", 64'(in_ready[0]), 64'h0);
    sv[0] = 1'b0;
    send_frag(0, 1);
    send_frag(0, 2);
    run_budget(5);   // header + 4 payload words: source 0 holds 4
    chk(throttle == 1'b1, "R9 throttle held in band", 64'(throttle), 64'h1);
    run_budget(1);   // source 0 holds 3
    chk(throttle == 1'b0, "R9 throttle falls below half", 64'(throttle), 64'h0);
    push_beat(0, dword(0, 0, 8), 1'b1, 1'b0, tag_of(0, 0));
    mode = 1;

    // Phase 2: many events with concurrent sources.
    for (int ev = 1; ev <= NEV; ev++) build_exp(ev);
    fork
      for (int ev = 1; ev <= NEV; ev++) send_frag(ev, 0);
      for (int ev = 1; ev <= NEV; ev++) send_frag(ev, 1);
      for (int ev = 1; ev <= NEV; ev++) send_frag(ev, 2);
    join
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
    chk(!out_valid, "R2 no header without data", 64'(out_valid), 64'h0);
    chk(!throttle, "R9 throttle idle at end", 64'(throttle), 64'h0);
    done = 1;
    summary();
  end
endmodule